// File: doc/BRIEF.md
# Variable-Length Instruction Pre-Decoder

This block sits between an instruction fetch stream and the decode stage. It takes 32-bit instruction words, each tagged with its fetch byte address, over a valid/ready handshake. For every instruction it finds where the instruction ends and which format class it belongs to. It then emits one record per instruction. A record carries:

- the instruction address;
- the first word, and the second word when there is one;
- the length in bytes and the next instruction address;
- the format class and an invalid flag.

Most instructions are one word. A memory-class instruction with a defined opcode and certain addressing modes carries a trailing 32-bit displacement word. For such an instruction the block keeps the first word internally and stalls nothing downstream until the second word arrives. A word whose class field is undefined yields an invalid record. The word that follows it is treated as the start of a fresh instruction.

Top module: `instr_predecode`

## Requirements
- R1: The format class is taken from bits 31:28 of the first word. Values 0 and 1 give control (code 0). Values 2 and 3 give compare-and-branch (code 1). Values 5 to 7 give register (code 2). Values 8 to 0xC give memory (code 3). Values 4 and 0xD to 0xF give the invalid class (code 4).
- R2: Control, compare-and-branch and register instructions have `out_len` = 4 and take exactly one input word.
- R3: A memory instruction has `out_len` = 8 and consumes two input words only when both of these hold:
  - its opcode (bits 31:24) is one of 0x80, 0x82, 0x84, 0x85, 0x86, 0x88, 0x8A, 0x8C, 0x90, 0x92, 0x98, 0x9A, 0xA0, 0xA2, 0xB0, 0xB2, 0xC0, 0xC2, 0xC8 or 0xCA;
  - its mode field (bits 13:10) is 5 or at least 12.
  Any other memory instruction has `out_len` = 4.
- R4: An invalid-class word gives a record with `out_invalid` = 1, `out_len` = 0 and `out_next_addr` equal to `out_addr`.
- R5: Each record holds the address of its first word, the first word itself, and `out_next_addr` = `out_addr` + `out_len`. `out_word1` holds the second word for 8-byte instructions and zero otherwise.
- R6: After an invalid record, the next input word is decoded as the first word of a new instruction.
- R7: Each input word is used exactly once. Records appear in input order. `in_ready` is low while a record waits with `out_ready` low.
- R8: While `out_valid` is high and `out_ready` is low, every record output holds its value.
- R9: Reset (active-low) drops any held first word and clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_word | input | 32 | Instruction word |
| in_addr | input | ADDR_W | Byte address of the input word |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_addr | output | ADDR_W | Address of the instruction |
| out_word0 | output | 32 | First word |
| out_word1 | output | 32 | Displacement word, or zero |
| out_len | output | 4 | Length in bytes: 0, 4 or 8 |
| out_class | output | 3 | Format class code |
| out_invalid | output | 1 | Invalid-class record |
| out_next_addr | output | ADDR_W | Address of the following instruction |

## Verification
A record becomes visible on the outputs one clock edge after the edge that accepts its last word: the first word for one-word instructions, the second word for two-word instructions. The driver decides acceptance by sampling `in_ready` shortly after the falling edge, once the consumer's `out_ready` for that cycle has settled. The monitor samples the outputs at the same point and compares a record against the expected queue only in a cycle where `out_valid` and `out_ready` are both high. A record held under back-pressure is compared again on the next falling edge to confirm it did not change.

// File: rtl/predec_pkg.sv
package predec_pkg;
  typedef enum logic [2:0] {
    CLS_CTRL  = 3'd0,
    CLS_CMPBR = 3'd1,
    CLS_REG   = 3'd2,
    CLS_MEM   = 3'd3,
    CLS_BAD   = 3'd4
  } fmt_class_e;

  localparam int unsigned INSN_W     = 32;
  localparam int unsigned LEN_W      = 4;
  localparam int unsigned WORD_BYTES = INSN_W / 8;
endpackage

// File: rtl/predec_classify.sv
module predec_classify
  import predec_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output fmt_class_e        cls,
  output logic              needs_ext
);
  logic [3:0] grp;
  logic [7:0] opc;
  logic [3:0] amode;
  logic       opc_known;
  logic       mode_ext;

  assign grp   = word[31:28];
  assign opc   = word[31:24];
  assign amode = word[13:10];

  always_comb begin
    unique case (grp)
      4'h0, 4'h1:                    cls = CLS_CTRL;
      4'h2, 4'h3:                    cls = CLS_CMPBR;
      4'h5, 4'h6, 4'h7:              cls = CLS_REG;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC:  cls = CLS_MEM;
      default:                       cls = CLS_BAD;
    endcase
  end

  always_comb begin
    case (opc)
      8'h80, 8'h82, 8'h84, 8'h85, 8'h86, 8'h88, 8'h8A, 8'h8C,
      8'h90, 8'h92, 8'h98, 8'h9A, 8'hA0, 8'hA2, 8'hB0, 8'hB2,
      8'hC0, 8'hC2, 8'hC8, 8'hCA: opc_known = 1'b1;
      default:                    opc_known = 1'b0;
    endcase
  end

  assign mode_ext  = (amode == 4'd5) || (amode >= 4'd12);
  assign needs_ext = (cls == CLS_MEM) && opc_known && mode_ext;
endmodule

// File: rtl/predec_seq.sv
module predec_seq
  import predec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              slot_free,
  input  logic              needs_ext,
  output logic              in_ready,
  output logic              fire_short,
  output logic              fire_pair,
  output logic [INSN_W-1:0] hold_word,
  output logic [ADDR_W-1:0] hold_addr
);
  logic waiting_q, waiting_d;
  logic take, start_pair;

  assign in_ready   = slot_free;
  assign take       = in_valid && in_ready;
  assign fire_short = take && !waiting_q && !needs_ext;
  assign start_pair = take && !waiting_q && needs_ext;
  assign fire_pair  = take && waiting_q;

  always_comb begin
    waiting_d = waiting_q;
    if (start_pair)     waiting_d = 1'b1;
    else if (fire_pair) waiting_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waiting_q <= 1'b0;
    else        waiting_q <= waiting_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_addr <= '0;
    end else if (start_pair) begin
      hold_word <= in_word;
      hold_addr <= in_addr;
    end
  end
endmodule

// File: rtl/instr_predecode.sv
module instr_predecode
  import predec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [31:0]       out_word0,
  output logic [31:0]       out_word1,
  output logic [3:0]        out_len,
  output logic [2:0]        out_class,
  output logic              out_invalid,
  output logic [ADDR_W-1:0] out_next_addr
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2 * WORD_BYTES);

  fmt_class_e        cls;
  logic              needs_ext, slot_free, fire_short, fire_pair, load;
  logic [INSN_W-1:0] hold_word;
  logic [ADDR_W-1:0] hold_addr;

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_d, next_d;
  logic [INSN_W-1:0] w0_d, w1_d;
  logic [LEN_W-1:0]  len_d;
  fmt_class_e        cls_d;
  logic              inv_d;

  predec_classify u_cls (
    .word      (in_word),
    .cls       (cls),
    .needs_ext (needs_ext)
  );

  predec_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_addr    (in_addr),
    .slot_free  (slot_free),
    .needs_ext  (needs_ext),
    .in_ready   (in_ready),
    .fire_short (fire_short),
    .fire_pair  (fire_pair),
    .hold_word  (hold_word),
    .hold_addr  (hold_addr)
  );

  assign slot_free = !vld_q || out_ready;
  assign load      = fire_short || fire_pair;

  always_comb begin
    if (fire_pair) begin
      addr_d = hold_addr;
      w0_d   = hold_word;
      w1_d   = in_word;
      len_d  = LEN_TWO;
      cls_d  = CLS_MEM;
      inv_d  = 1'b0;
    end else begin
      addr_d = in_addr;
      w0_d   = in_word;
      w1_d   = '0;
      cls_d  = cls;
      inv_d  = (cls == CLS_BAD);
      len_d  = inv_d ? '0 : LEN_ONE;
    end
    next_d = addr_d + ADDR_W'(len_d);
  end

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr      <= '0;
      out_word0     <= '0;
      out_word1     <= '0;
      out_len       <= '0;
      out_class     <= '0;
      out_invalid   <= 1'b0;
      out_next_addr <= '0;
    end else if (load) begin
      out_addr      <= addr_d;
      out_word0     <= w0_d;
      out_word1     <= w1_d;
      out_len       <= len_d;
      out_class     <= cls_d;
      out_invalid   <= inv_d;
      out_next_addr <= next_d;
    end
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/predec_checker.sv
module predec_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [31:0]       out_word0,
  input logic [3:0]        out_len,
  input logic [2:0]        out_class,
  input logic              out_invalid,
  input logic [ADDR_W-1:0] out_next_addr
);
  a_r2_short_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class <= 3'd2) |-> out_len == 4'd4);

  a_r3_long_is_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 4'd8) |-> out_class == 3'd3);

  a_r4_bad_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_len == 4'd0 && out_next_addr == out_addr));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_word0)
                                   && $stable(out_len)));
endmodule

bind instr_predecode predec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_word0     (out_word0),
  .out_len       (out_len),
  .out_class     (out_class),
  .out_invalid   (out_invalid),
  .out_next_addr (out_next_addr)
);

// File: tb/instr_predecode_test.sv
module instr_predecode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr, out_word0, out_word1, out_next_addr;
  logic [3:0]  out_len;
  logic [2:0]  out_class;
  logic        out_invalid;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [3:0]  len;
    logic [2:0]  cls;
    logic        inv;
  } rec_t;

  rec_t        expq[$];
  int          checks = 0;
  int          fails = 0;
  int          seen = 0;
  int          pushed = 0;
  logic [31:0] pc = 32'h0000_1000;
  bit          bp_on = 1'b0;
  int          bp_cnt = 0;

  instr_predecode uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_word0(out_word0),
    .out_word1(out_word1), .out_len(out_len), .out_class(out_class),
    .out_invalid(out_invalid), .out_next_addr(out_next_addr)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model_cls(input logic [31:0] w);
    case (w[31:28])
      4'h0, 4'h1:                   return 3'd0;
      4'h2, 4'h3:                   return 3'd1;
      4'h5, 4'h6, 4'h7:             return 3'd2;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC: return 3'd3;
      default:                      return 3'd4;
    endcase
  endfunction

  function automatic bit model_long(input logic [31:0] w);
    bit known;
    known = w[31:24] inside {8'h80, 8'h82, 8'h84, 8'h85, 8'h86, 8'h88, 8'h8A, 8'h8C,
                             8'h90, 8'h92, 8'h98, 8'h9A, 8'hA0, 8'hA2, 8'hB0, 8'hB2,
                             8'hC0, 8'hC2, 8'hC8, 8'hCA};
    return model_cls(w) == 3'd3 && known && (w[13:10] == 4'd5 || w[13:10] >= 4'd12);
  endfunction

  task automatic send_word(input logic [31:0] w, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_addr  = a;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Computes the expected record from R1-style rules, queues it, then drives words.
  task automatic send_insn(input logic [31:0] w0, input logic [31:0] disp);
    rec_t  r;
    r.addr = pc;
    r.w0   = w0;
    r.cls  = model_cls(w0);
    r.inv  = (r.cls == 3'd4);
    if (r.inv)             r.len = 4'd0;
    else if (model_long(w0)) r.len = 4'd8;
    else                   r.len = 4'd4;
    r.w1 = (r.len == 4'd8) ? disp : 32'h0;
    expq.push_back(r);
    pushed++;
    send_word(w0, pc);
    if (r.len == 4'd8) send_word(disp, pc + 32'd4);
    pc = pc + ((r.len == 4'd8) ? 32'd8 : 32'd4);
  endtask

  always @(negedge clk) begin
    bp_cnt++;
    out_ready <= bp_on ? ((bp_cnt % 3) != 0 && (bp_cnt % 7) != 2) : 1'b1;
  end

  rec_t held;
  bit   held_v = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held_v) begin
        chk(out_valid && out_addr == held.addr && out_word0 == held.w0 &&
            out_word1 == held.w1 && out_len == held.len, "R8 stalled record changed",
            {out_addr, out_word0}, {held.addr, held.w0});
        held_v = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held   = '{out_addr, out_word0, out_word1, out_len, out_class, out_invalid};
        held_v = 1'b1;
        chk(!in_ready, "R7 in_ready during stall", 64'(in_ready), 64'd0);
      end
      if (out_valid && out_ready) begin
        seen++;
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected record", 64'(out_addr), 64'd0);
        end else begin
          rec_t e;
          e = expq.pop_front();
          chk(out_class == e.cls, "R1 class", 64'(out_class), 64'(e.cls));
          chk(out_len == e.len, "R2/R3 length", 64'(out_len), 64'(e.len));
          chk(out_invalid == e.inv, "R4 invalid flag", 64'(out_invalid), 64'(e.inv));
          chk(out_addr == e.addr && out_word0 == e.w0, "R5 address/word0",
              {out_addr, out_word0}, {e.addr, e.w0});
          chk(out_word1 == e.w1, "R5 word1", 64'(out_word1), 64'(e.w1));
          chk(out_next_addr == e.addr + 32'(e.len), "R5 next address",
              64'(out_next_addr), 64'(e.addr + 32'(e.len)));
        end
      end
    end
  end

  task automatic run_set();
    send_insn(32'h0800_0010, 32'h0);        // control, R2
    send_insn(32'h3200_0000, 32'h0);        // compare-and-branch, R2
    send_insn(32'h5810_0000, 32'h0);        // register, R2
    send_insn(32'h9000_3000, 32'hDEAD_BEEF); // 0x90 mode 12: long, R3
    send_insn(32'h8C00_1400, 32'h1234_5678); // 0x8C mode 5: long, R3
    send_insn(32'h9000_1000, 32'h0);        // mode 4: short, R3
    send_insn(32'h8100_3000, 32'h0);        // undefined opcode: short, R3
    send_insn(32'hC000_2C00, 32'h0);        // mode 11 boundary: short, R3
    send_insn(32'hCA00_3C00, 32'hCAFE_F00D); // 0xCA mode 15: long, R3
    send_insn(32'h4000_0000, 32'h0);        // invalid class, R4
    send_insn(32'h1100_0000, 32'h0);        // resync after invalid, R6
    send_insn(32'hF000_0000, 32'h0);        // invalid class, R4
    send_insn(32'hD000_0000, 32'h0);        // invalid back to back, R6
    send_insn(32'hB000_3400, 32'h0BAD_0001); // long right after invalid, R6
    send_insn(32'h7000_0000, 32'h0);        // register, R2
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!out_valid, "R9 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!out_valid && in_ready, "R9 idle after reset", {63'd0, out_valid}, 64'd0);

    run_set();
    drain();

    bp_on = 1'b1;
    for (int k = 0; k < 4; k++) run_set();
    drain();
    bp_on = 1'b0;

    // R9: first word of a long instruction, then reset; it must never surface.
    send_word(32'h9200_3000, pc);
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk(!out_valid, "R9 reset clears output", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    pc = 32'h0000_8000;
    send_insn(32'h0900_0000, 32'h0);
    send_insn(32'h8400_3000, 32'h4444_0000);
    drain();

    chk(expq.size() == 0, "R7 all records delivered", 64'(expq.size()), 64'd0);
    chk(seen == pushed, "R7 record count", 64'(seen), 64'(pushed));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule